// File: doc/BRIEF.md
# Reset Source Discriminator

This block owns a shared, active-low reset pad. Pulling the pad low from outside resets the device. The pad is also an open-drain output. When a clock-monitor failure or a watchdog timeout arrives, the block pulls the pad low for a fixed stretch and then lets go. The logic never drives the pad high. A pull-up returns it high.

After the block lets go of the pad, it times how quickly the synchronized pad level returns high. It counts in E-clock cycles, qualified by `e_en`. If the pad is high before the window closes, the reset is classed as internal and the cause code names the failure source. If the pad is still low when the window closes, something outside is holding it, and the reset is classed as external. A slow RC network on the pad therefore reads as an external reset. This follows directly from the timing rule and is expected.

While the pad is low, and through the detection window, the core reset stays asserted. The cause code keeps its value until the next reset classifies again.

Top module: `rst_src_disc`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `core_rst` is 1, `pad_oe` is 0 and `cause` is 00. `core_rst` falls only once the synchronized pad reads high.
- R2: `pad_oe` = 1 means "pull the pad low". It rises only on the cycle after a failure pulse is seen with `core_rst` low. It then stays high for exactly `HOLD_E` (default 4) E-cycles, and `core_rst` is 1 throughout.
- R3: A clock-monitor failure whose pad returns high inside the window ends with `cause` = 01 and `core_rst` low. `cause` never takes the value 11.
- R4: A watchdog failure whose pad returns high inside the window ends with `cause` = 10.
- R5: When both failure inputs pulse in the same cycle, the clock monitor wins and `cause` = 01.
- R6: If the pad is still low after `WIN_E` (default 6) E-cycles from release, `cause` = 00 and `core_rst` stays 1 until the pad reads high.
- R7: With `core_rst` low, a pad pulled low from outside asserts `core_rst` and sets `cause` to 00. `core_rst` is released when the pad reads high again.
- R8: Failure pulses while `core_rst` is 1 are ignored. `pad_oe` stays 0 and no internal cause is recorded.
- R9: While `core_rst` stays low, `cause` does not change.
- R10: The pad input passes through a `SYNC_STAGES`-flop (default 2) synchronizer. With `core_rst` low, `core_rst` rises on the third clock edge after the pad falls.
- R11: The hold stretch and the window advance only on cycles with `e_en` = 1. The hold length is `HOLD_E` × E-period clocks (4 clocks when `e_en` is always 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| e_en | input | 1 | E-clock enable, one clock wide per E-cycle |
| pad_in | input | 1 | Raw level read from the reset pad |
| cmon_fail | input | 1 | Clock-monitor failure pulse |
| wdog_fail | input | 1 | Watchdog timeout pulse |
| pad_oe | output | 1 | Open-drain enable: 1 pulls the pad low |
| core_rst | output | 1 | Reset to the rest of the device, active high |
| cause | output | 2 | 00 external, 01 clock monitor, 10 watchdog |

## Verification
The bound checker watches, on every cycle, the invariants that hold whatever the pad does:
- `pad_oe` is only high inside a core reset.
- `pad_oe` only starts after a failure pulse seen out of reset.
- Each pull-low lasts exactly the hold length in E-cycles.
- Failure pulses during reset start no new pull-low.
- The cause code is always legal and is steady between resets.

Some behaviour depends on the pad's analog history, so only the bench scenarios can show it:
- a slow-rising pad being classed as external;
- an external hold overriding a cause recorded earlier;
- clock monitor winning over watchdog;
- the synchronizer latency.

The bench compares every clock against a behavioural model.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRIVE = 2'd1,
    ST_CHECK = 2'd2,
    ST_HOLD  = 2'd3
  } rsd_state_e;

  typedef logic [1:0] rsd_cause_t;

  localparam rsd_cause_t CAUSE_EXT  = 2'b00;
  localparam rsd_cause_t CAUSE_CMON = 2'b01;
  localparam rsd_cause_t CAUSE_WDOG = 2'b10;
endpackage

// File: rtl/rsd_sync.sv
module rsd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsd_fail_arb.sv
module rsd_fail_arb
  import rsd_pkg::*;
#(
  parameter bit CMON_FIRST = 1'b1
) (
  input  logic       cmon_fail,
  input  logic       wdog_fail,
  output logic       hit,
  output rsd_cause_t code
);
  assign hit = cmon_fail | wdog_fail;

  generate
    if (CMON_FIRST) begin : g_cmon_first
      always_comb begin
        if (cmon_fail)      code = CAUSE_CMON;
        else if (wdog_fail) code = CAUSE_WDOG;
        else                code = CAUSE_EXT;
      end
    end else begin : g_wdog_first
      always_comb begin
        if (wdog_fail)      code = CAUSE_WDOG;
        else if (cmon_fail) code = CAUSE_CMON;
        else                code = CAUSE_EXT;
      end
    end
  endgenerate
endmodule

// File: rtl/rsd_ecount.sv
module rsd_ecount #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] lim,
  output logic          at_lim
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + CW'(1);
  end

  // true when the next counted E-cycle completes the stretch
  assign at_lim = (cnt == (lim - CW'(1)));
endmodule

// File: rtl/rsd_ctrl.sv
module rsd_ctrl
  import rsd_pkg::*;
#(
  parameter int HOLD_E = 4,
  parameter int WIN_E  = 6,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          e_en,
  input  logic          pin_hi,
  input  logic          fail_hit,
  input  rsd_cause_t    fail_code,
  input  logic          cnt_at_lim,
  output logic          cnt_clr,
  output logic          cnt_step,
  output logic [CW-1:0] cnt_lim,
  output logic          pad_oe,
  output logic          core_rst,
  output rsd_cause_t    cause
);
  rsd_state_e state_q, state_d;
  rsd_cause_t src_q;
  logic       win_expired;

  always_comb begin
    state_d     = state_q;
    cnt_clr     = 1'b0;
    cnt_step    = 1'b0;
    cnt_lim     = CW'(HOLD_E);
    win_expired = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (!pin_hi) begin
          state_d = ST_HOLD;
        end else if (fail_hit) begin
          state_d = ST_DRIVE;
          cnt_clr = 1'b1;
        end
      end
      ST_DRIVE: begin
        cnt_step = e_en;
        if (e_en && cnt_at_lim) begin
          state_d = ST_CHECK;
          cnt_clr = 1'b1;
        end
      end
      ST_CHECK: begin
        cnt_lim = CW'(WIN_E);
        if (pin_hi) begin
          state_d = ST_RUN;
        end else begin
          cnt_step = e_en;
          if (e_en && cnt_at_lim) begin
            state_d     = ST_HOLD;
            win_expired = 1'b1;
          end
        end
      end
      default: begin
        if (pin_hi) state_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_HOLD;
      src_q    <= CAUSE_EXT;
      pad_oe   <= 1'b0;
      core_rst <= 1'b1;
      cause    <= CAUSE_EXT;
    end else begin
      state_q  <= state_d;
      pad_oe   <= (state_d == ST_DRIVE);
      core_rst <= (state_d != ST_RUN);
      if (state_q == ST_RUN && pin_hi && fail_hit) src_q <= fail_code;
      if (state_q == ST_RUN && !pin_hi)              cause <= CAUSE_EXT;
      else if (state_q == ST_CHECK && pin_hi)        cause <= src_q;
      else if (win_expired)                          cause <= CAUSE_EXT;
    end
  end
endmodule

// File: rtl/rst_src_disc.sv
module rst_src_disc
  import rsd_pkg::*;
#(
  parameter int HOLD_E      = 4,
  parameter int WIN_E       = 6,
  parameter int SYNC_STAGES = 2,
  parameter bit CMON_FIRST  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       e_en,
  input  logic       pad_in,
  input  logic       cmon_fail,
  input  logic       wdog_fail,
  output logic       pad_oe,
  output logic       core_rst,
  output logic [1:0] cause
);
  localparam int MAXC = (HOLD_E > WIN_E) ? HOLD_E : WIN_E;
  localparam int CW   = $clog2(MAXC + 1);

  logic          pin_hi;
  logic          fail_hit;
  rsd_cause_t    fail_code;
  logic          cnt_clr, cnt_step, cnt_at_lim;
  logic [CW-1:0] cnt_lim;
  rsd_cause_t    cause_q;

  rsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_hi)
  );

  rsd_fail_arb #(.CMON_FIRST(CMON_FIRST)) u_arb (
    .cmon_fail (cmon_fail),
    .wdog_fail (wdog_fail),
    .hit       (fail_hit),
    .code      (fail_code)
  );

  rsd_ecount #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (cnt_clr),
    .step   (cnt_step),
    .lim    (cnt_lim),
    .at_lim (cnt_at_lim)
  );

  rsd_ctrl #(.HOLD_E(HOLD_E), .WIN_E(WIN_E), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .e_en       (e_en),
    .pin_hi     (pin_hi),
    .fail_hit   (fail_hit),
    .fail_code  (fail_code),
    .cnt_at_lim (cnt_at_lim),
    .cnt_clr    (cnt_clr),
    .cnt_step   (cnt_step),
    .cnt_lim    (cnt_lim),
    .pad_oe     (pad_oe),
    .core_rst   (core_rst),
    .cause      (cause_q)
  );

  assign cause = cause_q;
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int HOLD_E = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       e_en,
  input logic       cmon_fail,
  input logic       wdog_fail,
  input logic       pad_oe,
  input logic       core_rst,
  input logic [1:0] cause
);
  localparam int HW = $clog2(HOLD_E + 2);
  logic [HW-1:0] hold_seen;

  always_ff @(posedge clk) begin
    if (rst || !pad_oe) hold_seen <= '0;
    else if (e_en)      hold_seen <= hold_seen + HW'(1);
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (core_rst && !pad_oe && cause == 2'b00));

  assert_oe_inside_reset_R2: assert property (@(posedge clk) disable iff (rst)
    pad_oe |-> core_rst);

  assert_oe_from_failure_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pad_oe) |-> ($past(cmon_fail || wdog_fail) && !$past(core_rst)));

  assert_hold_length_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(pad_oe) |-> (hold_seen == HW'(HOLD_E)));

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (rst)
    cause != 2'b11);

  assert_fail_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (core_rst && !pad_oe) |=> !pad_oe);

  assert_cause_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (!core_rst && !$past(core_rst)) |-> $stable(cause));
endmodule

bind rst_src_disc rsd_checker #(.HOLD_E(HOLD_E)) u_rsd_checker (
  .clk       (clk),
  .rst       (rst),
  .e_en      (e_en),
  .cmon_fail (cmon_fail),
  .wdog_fail (wdog_fail),
  .pad_oe    (pad_oe),
  .core_rst  (core_rst),
  .cause     (cause)
);

// File: tb/test_rst_src_disc.sv
`timescale 1ns/1ps
module test_rst_src_disc;
  localparam int HOLD = 4;
  localparam int WIN  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic e_en = 1'b0;
  logic cmf = 1'b0;
  logic wdt = 1'b0;
  logic ext_low = 1'b0;
  logic pad_in;
  logic pad_oe, core_rst;
  logic [1:0] cause;

  int checks = 0;
  int errors = 0;
  int e_per = 4;
  int e_ph = 0;
  string cur_req = "R1";
  bit started = 0;

  always #10 clk = ~clk;

  assign pad_in = !(pad_oe || ext_low);

  rst_src_disc i_rst_src_disc (
    .clk(clk), .rst(rst), .e_en(e_en), .pad_in(pad_in),
    .cmon_fail(cmf), .wdog_fail(wdt),
    .pad_oe(pad_oe), .core_rst(core_rst), .cause(cause)
  );

  // behavioural reference: mode 0 run, 1 pulling low, 2 timing rise, 3 waiting high
  int m_mode, m_cnt;
  int m_src, m_cause;
  bit m_oe, m_crst, m_s1, m_s2;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_mode = 3; m_cnt = 0; m_src = 0; m_cause = 0;
      m_oe = 0; m_crst = 1; m_s1 = 0; m_s2 = 0;
    end else begin
      case (m_mode)
        0: if (!m_s2) begin m_mode = 3; m_cause = 0; end
           else if (cmf || wdt) begin m_mode = 1; m_cnt = 0; m_src = cmf ? 1 : 2; end
        1: if (e_en) begin
             if (m_cnt == HOLD - 1) begin m_mode = 2; m_cnt = 0; end
             else m_cnt++;
           end
        2: if (m_s2) begin m_mode = 0; m_cause = m_src; end
           else if (e_en) begin
             if (m_cnt == WIN - 1) begin m_mode = 3; m_cause = 0; end
             else m_cnt++;
           end
        default: if (m_s2) m_mode = 0;
      endcase
      m_oe = (m_mode == 1);
      m_crst = (m_mode != 0);
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(pad_oe === m_oe, {cur_req, " pad_oe vs model"}, pad_oe, m_oe);
      chk(core_rst === m_crst, {cur_req, " core_rst vs model"}, core_rst, m_crst);
      chk(cause === 2'(m_cause), {cur_req, " cause vs model"}, cause, m_cause);
    end
    e_en = (e_ph == 0);
    e_ph = (e_ph + 1 >= e_per) ? 0 : e_ph + 1;
  end

  task automatic pulse(input bit c, input bit w);
    @(negedge clk); cmf = c; wdt = w;
    @(negedge clk); cmf = 0; wdt = 0;
  endtask

  task automatic wait_run();
    int n = 0;
    while (core_rst !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_oe(input bit v);
    int n = 0;
    while (pad_oe !== v && n < 500) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w;
    int hold_clks;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk(core_rst === 1'b1, "R1 core_rst in reset", core_rst, 1);
    chk(pad_oe === 1'b0, "R1 pad_oe in reset", pad_oe, 0);
    chk(cause === 2'b00, "R1 cause in reset", cause, 0);
    rst = 0;
    @(negedge clk);
    chk(core_rst === 1'b1, "R1 core_rst after reset", core_rst, 1);
    wait_run();
    chk(core_rst === 1'b0, "R1 core_rst released", core_rst, 0);

    cur_req = "R3";
    pulse(1, 0);
    wait_run();
    chk(cause === 2'b01, "R3 clock monitor cause", cause, 1);

    cur_req = "R4";
    pulse(0, 1);
    wait_run();
    chk(cause === 2'b10, "R4 watchdog cause", cause, 2);

    cur_req = "R5";
    pulse(1, 1);
    wait_run();
    chk(cause === 2'b01, "R5 both pulses, monitor wins", cause, 1);

    cur_req = "R9";
    repeat (60) @(negedge clk);
    chk(cause === 2'b01, "R9 cause steady while running", cause, 1);

    cur_req = "R6";
    pulse(0, 1);
    wait_oe(1);
    ext_low = 1;
    wait_oe(0);
    repeat (100) @(negedge clk);
    chk(core_rst === 1'b1, "R6 core_rst held while pad low", core_rst, 1);
    repeat (100) @(negedge clk);
    ext_low = 0;
    wait_run();
    chk(cause === 2'b00, "R6 slow pad classed external", cause, 0);

    cur_req = "R4";
    pulse(0, 1);
    wait_run();
    chk(cause === 2'b10, "R4 watchdog cause again", cause, 2);

    cur_req = "R10";
    @(negedge clk); ext_low = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(core_rst === 1'b0, "R10 core_rst before sync delay", core_rst, 0);
    @(negedge clk);
    chk(core_rst === 1'b1, "R10 core_rst after third edge", core_rst, 1);
    cur_req = "R7";
    chk(cause === 2'b00, "R7 external cause", cause, 0);

    cur_req = "R8";
    pulse(0, 1);
    pulse(1, 0);
    repeat (4) @(negedge clk);
    chk(pad_oe === 1'b0, "R8 failure ignored in reset", pad_oe, 0);
    ext_low = 0;
    cur_req = "R7";
    wait_run();
    chk(core_rst === 1'b0, "R7 released after pad high", core_rst, 0);
    chk(cause === 2'b00, "R8 no internal cause recorded", cause, 0);

    cur_req = "R2";
    pulse(1, 0);
    hold_clks = 0;
    w = 0;
    while (pad_oe === 1'b1 && w < 200) begin hold_clks++; @(negedge clk); w++; end
    chk(hold_clks >= 4 * HOLD - 3 && hold_clks <= 4 * HOLD, "R2 hold length at E/4", hold_clks, 4 * HOLD);
    wait_run();

    cur_req = "R11";
    e_per = 1;
    repeat (3) @(negedge clk);
    pulse(0, 1);
    hold_clks = 0;
    w = 0;
    while (pad_oe === 1'b1 && w < 200) begin hold_clks++; @(negedge clk); w++; end
    chk(hold_clks == HOLD, "R11 hold length with E every clock", hold_clks, HOLD);
    wait_run();
    chk(cause === 2'b10, "R11 short window still internal", cause, 2);

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule